// File: doc/BRIEF.md
# SPI Register Transaction Master

This block is an SPI master that runs complete register transactions against a slave that decodes an 8-bit command byte. A client hands it one request at a time: an operation code, a command byte, and an argument byte. The argument is the write data for a register write, or the byte count for a burst read. The block then holds chip select low for the whole transaction. It shifts out every byte on MOSI, most significant bit first, in SPI mode 0, and captures MISO on each rising SCLK edge.

A register write sends the command and then the data byte. A register read sends the command with bit 0 forced high and then one 0xFF dummy byte, and returns the byte captured in that dummy slot. A burst read sends a fixed command of 0x70, then the count N, then N dummy bytes, and returns one byte per dummy slot.

The request side is a valid/ready handshake. `req_ready` is high only while the block is idle, so a request offered during a transaction simply waits and is never lost or merged.

Read bytes leave through a valid/ready stream. `rd_valid` and `rd_data` hold until `rd_ready` is seen. If a captured byte has not been taken by the next byte boundary, the block parks with SCLK low and chip select still low until the byte is taken. A one-cycle `done` pulse marks chip-select release. A one-cycle `err` pulse marks a rejected request.

Top module: `spi_regseq_master`

## Requirements
- R1: SCLK is low whenever `cs_n` is high. MOSI changes only while SCLK is low or together with a falling SCLK edge. Every byte goes out MSB first, and MISO is captured on rising edges, eight edges per byte.
- R2: With parameter `CLK_HALF` = H (minimum 2), every SCLK high phase lasts H clock cycles. Every SCLK low phase inside a transaction also lasts H cycles, unless the read stream is stalled (R10).
- R3: `req_op` = 2'b00 (write) produces exactly two bytes under one low `cs_n`: `req_cmd` unchanged, then `req_arg`. No `rd_valid` is raised.
- R4: `req_op` = 2'b01 (read) produces two bytes: `req_cmd` with bit 0 set to 1, then 0xFF. The byte captured during the second slot is delivered once on `rd_data`.
- R5: `req_op` = 2'b10 (burst) produces 0x70, then `req_arg` = N, then N bytes of 0xFF, so 2+N bytes in all. The N bytes captured in the dummy slots are delivered in order. `req_cmd` is ignored for this operation.
- R6: The first rising SCLK edge comes H cycles after `cs_n` falls. `cs_n` rises H cycles after the last falling SCLK edge.
- R7: `req_ready` is high exactly when no transaction is in progress. A request held valid during a transaction starts nothing.
- R8: A burst request with N = 0, or `req_op` = 2'b11, is consumed and answered by a one-cycle `err` pulse. `cs_n` does not fall, and no `done` pulse follows.
- R9: `done` pulses for one cycle, in the first cycle that `cs_n` is high after a transaction.
- R10: While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_data` hold their values. At the next byte boundary SCLK stays low and `cs_n` stays low until the byte is taken, so no read byte is lost.
- R11: After reset, `cs_n` = 1, `sclk` = 0, `req_ready` = 1, and `rd_valid`, `done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken on this cycle if valid |
| req_op | input | 2 | 00 write, 01 read, 10 burst read, 11 reserved |
| req_cmd | input | 8 | Command byte (write/read) |
| req_arg | input | 8 | Write data, or burst byte count |
| rd_valid | output | 1 | Captured read byte available |
| rd_ready | input | 1 | Consumer accepts read byte |
| rd_data | output | 8 | Captured read byte |
| done | output | 1 | One-cycle pulse after chip select release |
| err | output | 1 | One-cycle pulse for a rejected request |
| sclk | output | 1 | SPI clock, idles low |
| mosi | output | 1 | Serial data to slave |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data from slave |

## Verification
With H = `CLK_HALF`, `cs_n` falls on the edge that accepts a request, and the first SCLK rise follows H cycles later. Each SCLK phase lasts H cycles. `rd_valid` rises one cycle after the eighth rising edge of a read slot. `cs_n` rises, together with `done`, H cycles after the last falling edge, and `err` is due one cycle after a rejected request is taken. The bench samples every port on the falling clock edge and measures these distances as cycle differences between observed transitions, rather than sampling at a fixed offset from the request. A back-pressure run holds `rd_ready` low for many SCLK periods and then checks that the stream and the bus froze at the boundary.

// File: rtl/spi_rseq_pkg.sv
package spi_rseq_pkg;

  localparam int BYTE_W = 8;
  localparam int IDX_W  = BYTE_W + 1;           // byte index up to 2 + 255
  localparam int BITS_W = $clog2(BYTE_W + 1);   // bit counter 0..8

  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_READ  = 2'b01,
    OP_BURST = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_STALL,
    ST_HOLD
  } st_e;

  // First byte on the wire for a given operation.
  function automatic logic [BYTE_W-1:0] cmd_byte(op_e op, logic [BYTE_W-1:0] cmd,
                                                 logic [BYTE_W-1:0] burst_cmd);
    case (op)
      OP_READ:  return cmd | BYTE_W'(1);
      OP_BURST: return burst_cmd;
      default:  return cmd;
    endcase
  endfunction

  // Bytes after the command: slot one carries the argument except on a read.
  function automatic logic [BYTE_W-1:0] later_byte(op_e op, logic [BYTE_W-1:0] arg,
                                                   logic [BYTE_W-1:0] dummy, logic second);
    if (second && op != OP_READ) return arg;
    return dummy;
  endfunction

  // Whether the byte at index idx returns data to the client.
  function automatic logic rd_slot(op_e op, logic [IDX_W-1:0] idx);
    case (op)
      OP_READ:  return idx == IDX_W'(1);
      OP_BURST: return idx >= IDX_W'(2);
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int HALF = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(HALF + 1);

  logic [CW-1:0] hcnt;

  assign tick = run && (hcnt == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)            hcnt <= '0;
    else if (!run || tick) hcnt <= '0;
    else                   hcnt <= hcnt + CW'(1);
  end

  // R2
  hcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt <= CW'(HALF - 1));

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int W  = 8,
  parameter int BW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  load_val,
  input  logic          rise,
  input  logic          fall,
  input  logic          miso,
  output logic          mosi,
  output logic [W-1:0]  rx_byte,
  output logic [BW-1:0] bits,
  output logic          got_byte
);
  logic [W-1:0] tx;

  assign mosi = tx[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx       <= '0;
      rx_byte  <= '0;
      bits     <= '0;
      got_byte <= 1'b0;
    end else begin
      got_byte <= rise && (bits == BW'(W - 1));
      if (load) begin
        tx   <= load_val;
        bits <= '0;
      end else begin
        if (fall) tx <= {tx[W-2:0], 1'b0};
        if (rise) begin
          rx_byte <= {rx_byte[W-2:0], miso};
          bits    <= bits + BW'(1);
        end
      end
    end
  end

  // R1
  rise_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> bits < BW'(W));

  // R1
  no_load_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && rise));

endmodule

// File: rtl/spi_rd_buffer.sv
module spi_rd_buffer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         rd_ready,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (push) begin
      rd_valid <= 1'b1;
      rd_data  <= push_data;
    end else if (rd_valid && rd_ready) begin
      rd_valid <= 1'b0;
    end
  end

  // R10
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !(rd_valid && !rd_ready));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

endmodule

// File: rtl/spi_regseq_master.sv
module spi_regseq_master
  import spi_rseq_pkg::*;
#(
  parameter int                CLK_HALF  = 3,
  parameter logic [BYTE_W-1:0] BURST_CMD = 8'h70,
  parameter logic [BYTE_W-1:0] DUMMY     = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [BYTE_W-1:0] req_cmd,
  input  logic [BYTE_W-1:0] req_arg,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [BYTE_W-1:0] rd_data,
  output logic              done,
  output logic              err,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  input  logic              miso
);
  localparam int HALF_EFF = (CLK_HALF < 2) ? 2 : CLK_HALF;

  st_e               st;
  op_e               cur_op;
  logic [BYTE_W-1:0] cur_arg;
  logic [IDX_W-1:0]  bidx, nbytes;

  logic              tick, run;
  logic              take, req_bad, rd_block, last_byte;
  logic              sh_rise, sh_fall, sh_load, byte_end, adv;
  logic [BYTE_W-1:0] load_val, rx_byte;
  logic [BITS_W-1:0] bits;
  logic              got_byte, push;

  assign req_ready = (st == ST_IDLE);
  assign take      = req_valid && req_ready;
  assign req_bad   = (op_e'(req_op) == OP_RSVD) ||
                     (op_e'(req_op) == OP_BURST && req_arg == '0);
  assign run       = (st == ST_SETUP) || (st == ST_SHIFT) || (st == ST_HOLD);
  assign rd_block  = rd_valid && !rd_ready;
  assign last_byte = (bidx + IDX_W'(1)) == nbytes;

  assign sh_rise  = tick && ((st == ST_SETUP) || (st == ST_SHIFT && !sclk));
  assign sh_fall  = tick && (st == ST_SHIFT) && sclk && (bits != BITS_W'(BYTE_W));
  assign byte_end = tick && (st == ST_SHIFT) && sclk && (bits == BITS_W'(BYTE_W));
  assign adv      = (byte_end && !last_byte && !rd_block) ||
                    ((st == ST_STALL) && !rd_block);
  assign sh_load  = (take && !req_bad) || adv;
  assign push     = got_byte && rd_slot(cur_op, bidx);

  always_comb begin
    if (st == ST_IDLE) load_val = cmd_byte(op_e'(req_op), req_cmd, BURST_CMD);
    else               load_val = later_byte(cur_op, cur_arg, DUMMY, bidx == '0);
  end

  spi_half_timer #(.HALF(HALF_EFF)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick)
  );

  spi_byte_shifter #(.W(BYTE_W), .BW(BITS_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sh_load),
    .load_val (load_val),
    .rise     (sh_rise),
    .fall     (sh_fall),
    .miso     (miso),
    .mosi     (mosi),
    .rx_byte  (rx_byte),
    .bits     (bits),
    .got_byte (got_byte)
  );

  spi_rd_buffer #(.W(BYTE_W)) u_rdbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (rx_byte),
    .rd_ready  (rd_ready),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cur_op  <= OP_WRITE;
      cur_arg <= '0;
      bidx    <= '0;
      nbytes  <= '0;
      cs_n    <= 1'b1;
      sclk    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        ST_IDLE: if (take) begin
          if (req_bad) begin
            err <= 1'b1;
          end else begin
            cs_n    <= 1'b0;
            cur_op  <= op_e'(req_op);
            cur_arg <= req_arg;
            bidx    <= '0;
            nbytes  <= (op_e'(req_op) == OP_BURST) ? ({1'b0, req_arg} + IDX_W'(2))
                                                   : IDX_W'(2);
            st      <= ST_SETUP;
          end
        end
        ST_SETUP: if (tick) begin
          sclk <= 1'b1;
          st   <= ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          if (!sclk) begin
            sclk <= 1'b1;
          end else begin
            sclk <= 1'b0;
            if (bits == BITS_W'(BYTE_W)) begin
              if (last_byte)     st   <= ST_HOLD;
              else if (rd_block) st   <= ST_STALL;
              else               bidx <= bidx + IDX_W'(1);
            end
          end
        end
        ST_STALL: if (!rd_block) begin
          bidx <= bidx + IDX_W'(1);
          st   <= ST_SHIFT;
        end
        ST_HOLD: if (tick) begin
          cs_n <= 1'b1;
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R1
  mosi_hi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R7
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !req_ready);

  // R9
  done_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && $past(!cs_n)));

  // R8
  err_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (cs_n && !done));

  // R10
  stall_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STALL) |-> (!sclk && !cs_n && rd_valid));

endmodule

// File: tb/tb_spi_regseq_master.sv
module tb_spi_regseq_master;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;
  localparam int WDOG       = 150000;

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] cmd;
    logic [7:0] arg;
    logic [7:0] b0;
    logic [7:0] b1;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{2'b00, 8'h10, 8'hA5, 8'h10, 8'hA5},
    '{2'b00, 8'h40, 8'h3C, 8'h40, 8'h3C},
    '{2'b01, 8'h20, 8'h00, 8'h21, 8'hFF},
    '{2'b01, 8'h31, 8'h77, 8'h31, 8'hFF},
    '{2'b10, 8'h00, 8'h01, 8'h70, 8'h01},
    '{2'b10, 8'h12, 8'h05, 8'h70, 8'h05},
    '{2'b00, 8'h30, 8'h00, 8'h30, 8'h00},
    '{2'b01, 8'h40, 8'h00, 8'h41, 8'hFF},
    '{2'b10, 8'h55, 8'h03, 8'h70, 8'h03}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, rd_ready = 1'b1, miso = 1'b0;
  logic [1:0] req_op = '0;
  logic [7:0] req_cmd = '0, req_arg = '0;
  logic req_ready, rd_valid, done, err, sclk, mosi, cs_n;
  logic [7:0] rd_data;

  int nchk = 0, nerr = 0;

  spi_regseq_master #(.CLK_HALF(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_cmd(req_cmd), .req_arg(req_arg),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .err(err), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] pat(logic [7:0] base, int k);
    return base + 8'(k) * 8'h1D;
  endfunction

  // Monitor and slave model, all at the falling clock edge.
  logic [7:0] cur_base = 8'h00;
  logic [7:0] mosi_log [0:299];
  logic [7:0] rd_log   [0:299];
  logic [7:0] s_rx = '0, tmpb;
  logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_mosi = 1'b0;
  logic first_rise = 1'b0, allow_stall = 1'b0;
  int cyc = 0, t_csf = 0, t_rise = 0, t_fall = 0;
  int s_bit = 0, s_byte = 0, mosi_n = 0, rd_n = 0;
  int setup_v = 0, hold_v = 0, end_bits = 0;
  int hi_bad = 0, lo_bad = 0, mosi_bad = 0, idle_bad = 0, busy_bad = 0;
  int done_n = 0, err_n = 0, cs_falls = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_cs && !cs_n) begin
        cs_falls++; t_csf = cyc; first_rise = 1'b1;
        s_bit = 0; s_byte = 0; mosi_n = 0;
        tmpb = pat(cur_base, 0); miso = tmpb[7];
      end
      if (!prev_sclk && sclk) begin
        if (first_rise) begin setup_v = cyc - t_csf; first_rise = 1'b0; end
        else if (!allow_stall && (cyc - t_fall) != HALF) lo_bad++;
        t_rise = cyc;
        s_rx = {s_rx[6:0], mosi}; s_bit++;
        if (s_bit == 8) begin
          mosi_log[mosi_n] = s_rx; mosi_n++; s_bit = 0; s_byte++;
        end
      end
      if (prev_sclk && !sclk) begin
        if ((cyc - t_rise) != HALF) hi_bad++;
        t_fall = cyc;
        tmpb = pat(cur_base, s_byte); miso = tmpb[7 - s_bit];
      end
      if (!prev_cs && cs_n) begin hold_v = cyc - t_fall; end_bits = s_bit; end
      if (prev_sclk && sclk && mosi !== prev_mosi) mosi_bad++;
      if (cs_n && sclk) idle_bad++;
      if (!cs_n && req_ready) busy_bad++;
      if (done) done_n++;
      if (err) err_n++;
      if (rd_valid && rd_ready) begin rd_log[rd_n] = rd_data; rd_n++; end
    end
    prev_cs = cs_n; prev_sclk = sclk; prev_mosi = mosi;
  end

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic clear_counts();
    rd_n = 0; done_n = 0; err_n = 0; cs_falls = 0;
    hi_bad = 0; lo_bad = 0; mosi_bad = 0; idle_bad = 0; busy_bad = 0;
  endtask

  task automatic start_txn(input logic [1:0] op, input logic [7:0] cmd, input logic [7:0] arg);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_cmd = cmd; req_arg = arg;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_end();
    int lim = 0;
    while (done_n == 0 && err_n == 0 && lim < 5000) begin @(negedge clk); lim++; end
    check("R9 transaction finished", int'(lim < 5000), 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired (all requirements)");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    string tag;
    int nb, nrd;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 cs_n", cs_n, 1);
    check("R11 sclk", sclk, 0);
    check("R11 req_ready", req_ready, 1);
    check("R11 rd_valid", rd_valid, 0);
    check("R11 done", done, 0);
    check("R11 err", err, 0);

    foreach (VECS[i]) begin
      cur_base = 8'h30 + 8'(i) * 8'h13;
      clear_counts();
      start_txn(VECS[i].op, VECS[i].cmd, VECS[i].arg);
      wait_end();
      case (VECS[i].op)
        2'b00:   tag = "R3";
        2'b01:   tag = "R4";
        default: tag = "R5";
      endcase
      nb  = (VECS[i].op == 2'b10) ? int'(VECS[i].arg) + 2 : 2;
      nrd = (VECS[i].op == 2'b00) ? 0 : (VECS[i].op == 2'b01) ? 1 : int'(VECS[i].arg);
      check({tag, " byte count"}, mosi_n, nb);
      check({tag, " command byte"}, mosi_log[0], VECS[i].b0);
      check({tag, " second byte"}, mosi_log[1], VECS[i].b1);
      for (int k = 2; k < nb; k++) check({tag, " dummy byte"}, mosi_log[k], 8'hFF);
      check({tag, " read byte count"}, rd_n, nrd);
      for (int k = 0; k < nrd; k++)
        check({tag, " read data"}, rd_log[k], pat(cur_base, (VECS[i].op == 2'b01) ? 1 : k + 2));
      check("R1 mosi stable while sclk high", mosi_bad, 0);
      check("R1 sclk low while deselected", idle_bad, 0);
      check("R1 whole bytes only", end_bits, 0);
      check("R2 high phase width", hi_bad, 0);
      check("R2 low phase width", lo_bad, 0);
      check("R6 setup cycles", setup_v, HALF);
      check("R6 hold cycles", hold_v, HALF);
      check("R9 one done pulse", done_n, 1);
      check("R8 no err on valid request", err_n, 0);
    end

    // R7: request held during a busy burst is not taken
    cur_base = 8'hC1;
    clear_counts();
    start_txn(2'b10, 8'h00, 8'h04);
    repeat (30) @(negedge clk);
    req_valid = 1'b1; req_op = 2'b00; req_cmd = 8'h10; req_arg = 8'h5A;
    repeat (20) @(negedge clk);
    req_valid = 1'b0;
    wait_end();
    check("R7 single chip-select cycle", cs_falls, 1);
    check("R7 ready low while busy", busy_bad, 0);
    check("R7 burst length unaffected", mosi_n, 6);
    check("R7 single done", done_n, 1);

    // R8: zero-count burst and reserved op are rejected
    clear_counts();
    start_txn(2'b10, 8'h70, 8'h00);
    repeat (10) @(negedge clk);
    check("R8 err on zero count", err_n, 1);
    check("R8 no done on zero count", done_n, 0);
    check("R8 no chip select on zero count", cs_falls, 0);
    clear_counts();
    start_txn(2'b11, 8'h10, 8'h22);
    repeat (10) @(negedge clk);
    check("R8 err on reserved op", err_n, 1);
    check("R8 no chip select on reserved op", cs_falls, 0);
    check("R8 ready again", req_ready, 1);

    // R10: read back-pressure stalls the bus at a byte boundary
    begin
      logic [7:0] d0;
      int lim = 0;
      cur_base = 8'h5E;
      clear_counts();
      allow_stall = 1'b1;
      rd_ready = 1'b0;
      start_txn(2'b10, 8'h00, 8'h03);
      while (!rd_valid && lim < 2000) begin @(negedge clk); lim++; end
      d0 = rd_data;
      check("R10 first burst byte", d0, pat(cur_base, 2));
      repeat (60) @(negedge clk);
      check("R10 rd_valid held", rd_valid, 1);
      check("R10 rd_data held", rd_data, d0);
      check("R10 sclk parked low", sclk, 0);
      check("R10 chip select held", cs_n, 0);
      check("R10 bytes sent before stall", mosi_n, 3);
      rd_ready = 1'b1;
      wait_end();
      allow_stall = 1'b0;
      check("R10 all bytes delivered", rd_n, 3);
      for (int k = 0; k < 3; k++) check("R10 burst data order", rd_log[k], pat(cur_base, k + 2));
      check("R10 total bytes", mosi_n, 5);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule